// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block sits between a maintenance request source and the command queue of a set-associative cache. A request gives a start address, an end address (exclusive) and an operation code such as invalidate, clean or flush. The block widens the span to whole cache lines and cuts it into range commands that the queue can take one at a time. Every command it issues is bounded in size.

When the widened span reaches to within one line of the whole address space, the block issues a single entire-cache command instead of range commands. Every request ends with a sync command, which tells the queue to drain its buffers.

Requests arrive on a valid/ready channel. Commands leave on a valid/ready channel that carries a mode, the operation code, an address and a size. The block works on one request at a time. It presents the next command only after the current one has been accepted.

Top module: `cmo_range_splitter`

## Requirements
- R1: Out of reset, `req_ready` is 1 and `cmd_valid` is 0.
- R2: The address of the first range command is the request start rounded down to a multiple of `LINE_BYTES`. Every range address and size is a multiple of `LINE_BYTES`.
- R3: Let raw = end − aligned start, modulo 2^ADDR_W. The range commands of one request cover exactly raw rounded up to a multiple of `LINE_BYTES`, as contiguous ascending pieces.
- R4: Each range command has size min(remaining, `MAX_CHUNK` − `LINE_BYTES`). The next command's address is the previous address plus the previous size.
- R5: If raw ≥ 2^ADDR_W − `LINE_BYTES`, the block issues exactly one entire-cache command instead of range commands. The wrapped case, where end is below start, is included. Its address and size are 0.
- R6: The block always follows the last range command, or the entire-cache command, with one sync command (address 0, size 0). If the rounded size is 0, the sync command is the only command issued.
- R7: `req_ready` stays 0 from the cycle after a request is accepted until the sync command is accepted. A `req_valid` raised in that time has no effect on the commands issued.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, mode, op, address and size hold steady.
- R9: Mode encoding is 0 = range, 1 = entire cache, 2 = sync. `cmd_op` equals the request's op code on every command of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_start | input | ADDR_W | First byte address of span |
| req_end | input | ADDR_W | Address one past the span |
| req_op | input | OP_W | Maintenance operation code |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Queue accepts the command |
| cmd_mode | output | 2 | 0 range, 1 entire cache, 2 sync |
| cmd_op | output | OP_W | Operation code of the command |
| cmd_addr | output | ADDR_W | Range start (0 otherwise) |
| cmd_size | output | ADDR_W | Range size in bytes (0 otherwise) |

## Verification
The bench builds the block with a 16-bit address, 16-byte lines and a 64-byte limit, so each chunk is capped at 48 bytes. With these values a span of a few lines already splits into several chunks, including a final partial chunk. The 16-bit address lets the bench reach the top of the address space, the wrap-around and the entire-cache threshold. It also runs the span one line below that threshold, which yields 1365 chunks, in a few thousand cycles.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [1:0] {
    CMD_RANGE = 2'd0,
    CMD_ALL   = 2'd1,
    CMD_SYNC  = 2'd2
  } cmd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RANGE = 2'd1,
    ST_ALL   = 2'd2,
    ST_SYNC  = 2'd3
  } split_state_e;
endpackage

// File: rtl/cmo_span_calc.sv
module cmo_span_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] total_o,
  output logic              whole_o
);
  localparam int LINE_LG = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] NEG_LINE  = ~LINE_MASK;

  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] bump;

  always_comb begin
    base_o  = {start_i[ADDR_W-1:LINE_LG], {LINE_LG{1'b0}}};
    raw     = end_i - base_o;
    whole_o = (raw >= NEG_LINE);
    bump    = raw + LINE_MASK;
    total_o = {bump[ADDR_W-1:LINE_LG], {LINE_LG{1'b0}}};
  end
endmodule

// File: rtl/cmo_chunk_sel.sv
module cmo_chunk_sel #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CAP = '1
) (
  input  logic [ADDR_W-1:0] remaining_i,
  output logic [ADDR_W-1:0] chunk_o,
  output logic              last_o
);
  always_comb begin
    last_o  = (remaining_i <= CAP);
    chunk_o = last_o ? remaining_i : CAP;
  end
endmodule

// File: rtl/cmo_range_splitter.sv
module cmo_range_splitter
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OP_W       = 2,
  parameter int LINE_BYTES = 128,
  parameter int MAX_CHUNK  = 1 << 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [OP_W-1:0]   req_op,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_mode,
  output logic [OP_W-1:0]   cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_size
);
  localparam logic [ADDR_W-1:0] CAP = ADDR_W'(MAX_CHUNK - LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  split_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] rem_q, rem_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic              data_en;

  logic [ADDR_W-1:0] span_base, span_total;
  logic              span_whole;
  logic [ADDR_W-1:0] chunk;
  logic              chunk_last;

  cmo_span_calc #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_span (
    .start_i (req_start),
    .end_i   (req_end),
    .base_o  (span_base),
    .total_o (span_total),
    .whole_o (span_whole)
  );

  cmo_chunk_sel #(.ADDR_W(ADDR_W), .CAP(CAP)) u_chunk (
    .remaining_i (rem_q),
    .chunk_o     (chunk),
    .last_o      (chunk_last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    op_d    = op_q;
    data_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          data_en = 1'b1;
          addr_d  = span_base;
          rem_d   = span_total;
          op_d    = req_op;
          if (span_whole)            state_d = ST_ALL;
          else if (span_total == '0) state_d = ST_SYNC;
          else                       state_d = ST_RANGE;
        end
      end
      ST_RANGE: begin
        if (cmd_ready) begin
          data_en = 1'b1;
          addr_d  = addr_q + chunk;
          rem_d   = rem_q - chunk;
          if (chunk_last) state_d = ST_SYNC;
        end
      end
      ST_ALL:  if (cmd_ready) state_d = ST_SYNC;
      ST_SYNC: if (cmd_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (data_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
        op_q   <= op_d;
      end
    end
  end

  // outputs
  always_comb begin
    req_ready = (state_q == ST_IDLE);
    cmd_valid = (state_q != ST_IDLE);
    cmd_op    = op_q;
    cmd_addr  = '0;
    cmd_size  = '0;
    cmd_mode  = CMD_SYNC;
    unique case (state_q)
      ST_RANGE: begin
        cmd_mode = CMD_RANGE;
        cmd_addr = addr_q;
        cmd_size = chunk;
      end
      ST_ALL:  cmd_mode = CMD_ALL;
      default: cmd_mode = CMD_SYNC;
    endcase
  end

  // assertions
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_mode) &&
      $stable(cmd_addr) && $stable(cmd_size) && $stable(cmd_op)));

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == CMD_RANGE) |->
      ((cmd_addr & LINE_MASK) == '0 && (cmd_size & LINE_MASK) == '0));

  assert_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == CMD_RANGE) |-> (cmd_size != '0 && cmd_size <= CAP));

  assert_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mode == CMD_RANGE) |=>
      (cmd_mode == CMD_SYNC || cmd_addr == $past(cmd_addr) + $past(cmd_size)));

  assert_sync_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mode == CMD_ALL) |=>
      (cmd_valid && cmd_mode == CMD_SYNC));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mode == CMD_SYNC) |=> (req_ready && !cmd_valid));
endmodule

// File: tb/cmo_range_splitter_test.sv
module cmo_range_splitter_test;
  localparam int AW   = 16;
  localparam int OW   = 2;
  localparam int LINE = 16;
  localparam int MAXC = 64;
  localparam logic [AW-1:0] CAPV = AW'(MAXC - LINE);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_end = '0;
  logic [OW-1:0] req_op = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [1:0]    cmd_mode;
  logic [OW-1:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [AW-1:0] cmd_size;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cmo_range_splitter #(.ADDR_W(AW), .OP_W(OW), .LINE_BYTES(LINE), .MAX_CHUNK(MAXC)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_end(req_end), .req_op(req_op),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_size(cmd_size)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // wait for a command, compare it, optionally stall/poke, then accept it
  task automatic take_cmd(input logic [1:0] mode, input logic [AW-1:0] addr,
                          input logic [AW-1:0] size, input logic [OW-1:0] op,
                          input bit stall, input bit poke, input string req);
    int n = 0;
    while (!cmd_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(cmd_valid == 1'b1, req, "cmd_valid", int'(cmd_valid), 1);
    chk(cmd_mode == mode, "R9", "mode", int'(cmd_mode), int'(mode));
    chk(cmd_addr == addr, req, "addr", int'(cmd_addr), int'(addr));
    chk(cmd_size == size, req, "size", int'(cmd_size), int'(size));
    chk(cmd_op == op, "R9", "op", int'(cmd_op), int'(op));
    if (stall) begin
      if (poke) begin
        req_valid = 1'b1;
        req_start = 16'h4000;
        req_end   = 16'h4100;
        req_op    = ~op;
      end
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0, "R7", "req_ready busy", int'(req_ready), 0);
      chk(cmd_valid && cmd_mode == mode && cmd_addr == addr && cmd_size == size,
          "R8", "held addr", int'(cmd_addr), int'(addr));
      req_valid = 1'b0;
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic run_req(input logic [AW-1:0] s, input logic [AW-1:0] e,
                         input logic [OW-1:0] op, input bit stall, input bit poke,
                         input string req);
    logic [AW-1:0] base, raw, left, a, c;
    base = s & ~AW'(LINE - 1);
    raw  = e - base;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready before request", int'(req_ready), 1);
    req_start = s;
    req_end   = e;
    req_op    = op;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (raw >= AW'(-LINE)) begin
      take_cmd(2'd1, '0, '0, op, stall, poke, "R5");
    end else begin
      left = (raw + AW'(LINE - 1)) & ~AW'(LINE - 1);
      a = base;
      while (left != '0) begin
        c = (left > CAPV) ? CAPV : left;
        take_cmd(2'd0, a, c, op, stall, poke, req);
        a = a + c;
        left = left - c;
      end
    end
    take_cmd(2'd2, '0, '0, op, 1'b0, 1'b0, "R6");
    chk(!cmd_valid && req_ready, "R6", "idle after sync", int'(cmd_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid", int'(cmd_valid), 0);
  endtask

  task automatic t_aligned();     run_req(16'h0100, 16'h0120, 2'd0, 0, 0, "R2"); endtask
  task automatic t_unaligned();   run_req(16'h0105, 16'h0131, 2'd1, 0, 0, "R3"); endtask
  task automatic t_multi_stall(); run_req(16'h1000, 16'h10A0, 2'd2, 1, 1, "R4"); endtask
  task automatic t_exact();       run_req(16'h0200, 16'h0290, 2'd1, 0, 0, "R4"); endtask
  task automatic t_zero();        run_req(16'h0308, 16'h0300, 2'd0, 0, 0, "R6"); endtask
  task automatic t_top();         run_req(16'hFFE5, 16'hFFFF, 2'd2, 0, 0, "R3"); endtask
  task automatic t_all();         run_req(16'h0000, 16'hFFF0, 2'd2, 1, 1, "R5"); endtask
  task automatic t_wrap();        run_req(16'h0010, 16'h0000, 2'd1, 0, 0, "R5"); endtask
  task automatic t_below_all();   run_req(16'h0000, 16'hFFEF, 2'd0, 0, 0, "R3"); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_aligned();
    t_unaligned();
    t_multi_stall();
    t_exact();
    t_zero();
    t_top();
    t_all();
    t_wrap();
    t_below_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule